// File: doc/BRIEF.md
# Cascadable Timer Pair Clock Selector

The block holds two 8-bit up-counters, a lower channel (A) and an upper channel (B). A 3-bit select field on each channel decides what makes its counter step. The options are:

- no source, which stops the counter;
- one of three taps of a shared free-running prescaler;
- the rising, falling or both edges of an external clock pin, which is first synchronized to the system clock;
- a cascade source taken from the partner channel.

The cascade is asymmetric. The lower channel steps on each overflow of the upper channel, which forms a 16-bit counter with B as the low byte. The upper channel steps on each match of the lower channel against its match register.

Each channel has a match register and drives two one-cycle pulses: one on overflow and one on match. Software reads and writes the select fields, the counters and the match registers through a plain register port. Writes take effect at the clock edge, and reads are combinational.

Top module: `tmr_pair_clksel`

## Requirements
- R1: After reset, both select fields, both counters and both match registers read 0, and all four pulse outputs are low.
- R2: Select code 0 (binary 000) holds the counter at its value, whatever the prescaler or the external pin does.
- R3: Code 1 steps the counter once per 8 system clocks, code 2 once per 64 and code 3 once per 8192. Each step falls on the cycle in which that prescaler tap goes from 1 to 0.
- R4: Code 5 steps the counter on each rising edge of the synchronized external pin, code 6 on each falling edge and code 7 on both edges.
- R5: Code 4 on channel A steps A once for each overflow of channel B, so that A:B counts as one 16-bit value.
- R6: Code 4 on channel B steps B once for each match pulse of channel A.
- R7: When both channels hold code 4, neither counter ever steps.
- R8: A counter that steps from 0xFF to 0x00 raises its overflow output for exactly one cycle.
- R9: A step that makes a counter equal to its match register raises that channel's match output for exactly one cycle. When the counter moves on, no further match pulse follows.
- R10: A register write to a counter takes priority over a step in the same cycle. The written value is loaded, and no overflow or match pulse is raised for that cycle.
- R11: The register map is as follows. Address 0 holds the A select field and address 1 the B select field, each in bits 2:0, with bits 7:3 reading 0. Addresses 2 and 3 hold counters A and B. Addresses 4 and 5 hold the A and B match registers. Addresses 6 and 7 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk | input | 1 | Asynchronous external count clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| ovf_a | output | 1 | Channel A overflow pulse |
| ovf_b | output | 1 | Channel B overflow pulse |
| match_a | output | 1 | Channel A match pulse |
| match_b | output | 1 | Channel B match pulse |

## Verification
The timings below count clock edges after each stimulus:

- A register write is visible at the read port one edge after the strobe.
- A prescaler tap registers its pulse on the edge at which the tap falls, and the counter steps on the following edge.
- An external pin edge needs two synchronizer edges and one detection stage, so the counter steps on the third edge after the pin changes.
- A cascade step lands one edge after the partner's registered pulse.

The bench drives on falling clock edges and samples on falling edges. It holds every external level for three cycles and lets four more cycles pass before it reads. Prescaler rates are measured over windows that are whole multiples of the tap period, so the prescaler phase cancels out. The write-priority case aligns a write with a known tap step by counting edges since reset. Pulse widths are counted cycle by cycle at falling edges.

// File: rtl/tmr_pair_pkg.sv
// Shared types and register addresses for the cascadable timer pair.
package tmr_pair_pkg;

    // Per-channel count source encoding; the numeric values are software-visible.
    typedef enum logic [2:0] {
        SEL_OFF      = 3'd0,
        SEL_DIV_LO   = 3'd1,
        SEL_DIV_MID  = 3'd2,
        SEL_DIV_HI   = 3'd3,
        SEL_CASCADE  = 3'd4,
        SEL_EXT_RISE = 3'd5,
        SEL_EXT_FALL = 3'd6,
        SEL_EXT_BOTH = 3'd7
    } clk_sel_e;

    // Register addresses: base plus channel index (0 = A, 1 = B).
    localparam logic [2:0] ADDR_SEL_BASE   = 3'd0;
    localparam logic [2:0] ADDR_CNT_BASE   = 3'd2;
    localparam logic [2:0] ADDR_MATCH_BASE = 3'd4;

endpackage

// File: rtl/tmr_prescaler.sv
// Free-running prescaler with three taps.
// Each tap output is a one-cycle pulse registered on the cycle in which
// counter bit (LOG-1) falls from 1 to 0, i.e. once every 2**LOG cycles.
// Assumes LOG_LO <= LOG_MID <= LOG_HI, all at least 1.
module tmr_prescaler #(
    parameter int LOG_LO  = 3,
    parameter int LOG_MID = 6,
    parameter int LOG_HI  = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [2:0] tick
);
    localparam int CNT_W = LOG_HI;

    logic [CNT_W-1:0] cnt_q;

    // Divide counter, runs from reset onward.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    for (genvar i = 0; i < 3; i++) begin : g_tap
        localparam int L = (i == 0) ? LOG_LO : (i == 1) ? LOG_MID : LOG_HI;
        logic tick_q;

        // Pulse when the low L bits roll over, which is the fall of bit L-1.
        always_ff @(posedge clk) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= &cnt_q[L-1:0];
        end
        assign tick[i] = tick_q;

        // R3: a tap pulse coincides with the low bits having just rolled to zero
        a_r3_tick_at_roll: assert property (@(posedge clk) disable iff (!rst_n)
            tick_q |-> (cnt_q[L-1:0] == '0));
        // R3: a tap pulse lasts one cycle
        a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
            tick_q |=> !tick_q);
    end

endmodule

// File: rtl/tmr_ext_edge.sv
// Two-flop synchronizer for the external count clock, followed by edge
// detection against the previous synchronized sample.
// Assumes ext_clk levels are held for at least two system clocks.
module tmr_ext_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    output logic rise,
    output logic fall
);
    logic [1:0] sync_q;
    logic       prev_q;

    // Synchronize the pin and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], ext_clk};
            prev_q <= sync_q[1];
        end
    end

    assign rise =  sync_q[1] & ~prev_q;
    assign fall = ~sync_q[1] &  prev_q;

    // R4: a detected edge is one cycle long for a held pin level
    a_r4_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    a_r4_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/tmr_channel.sv
// One timer channel: select register, up-counter and match register.
// Picks its step enable from the select code and raises registered
// one-cycle overflow and match pulses. A counter write wins over a step.
// Assumes casc_in is already a one-cycle pulse from the partner channel.
module tmr_channel
    import tmr_pair_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   tick,
    input  logic         ext_rise,
    input  logic         ext_fall,
    input  logic         casc_in,
    input  logic         casc_block,
    input  logic         wr_sel,
    input  logic         wr_cnt,
    input  logic         wr_match,
    input  logic [W-1:0] wr_data,
    output clk_sel_e     sel,
    output logic [W-1:0] cnt,
    output logic [W-1:0] match_val,
    output logic         ovf,
    output logic         hit
);
    localparam logic [W-1:0] CNT_MAX = '1;

    clk_sel_e     sel_q;
    logic [W-1:0] cnt_q, match_q, cnt_nxt;
    logic         inc, ovf_q, hit_q;

    // Step-enable selection from the select code.
    always_comb begin
        unique case (sel_q)
            SEL_DIV_LO:   inc = tick[0];
            SEL_DIV_MID:  inc = tick[1];
            SEL_DIV_HI:   inc = tick[2];
            SEL_CASCADE:  inc = casc_in & ~casc_block;
            SEL_EXT_RISE: inc = ext_rise;
            SEL_EXT_FALL: inc = ext_fall;
            SEL_EXT_BOTH: inc = ext_rise | ext_fall;
            default:      inc = 1'b0;
        endcase
    end

    assign cnt_nxt = cnt_q + 1'b1;

    // Registers, counter update and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= SEL_OFF;
            cnt_q   <= '0;
            match_q <= '0;
            ovf_q   <= 1'b0;
            hit_q   <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            hit_q <= 1'b0;
            if (wr_cnt) begin
                cnt_q <= wr_data;
            end else if (inc) begin
                cnt_q <= cnt_nxt;
                ovf_q <= (cnt_q == CNT_MAX);
                hit_q <= (cnt_nxt == match_q);
            end
            if (wr_match) match_q <= wr_data;
            if (wr_sel)   sel_q   <= clk_sel_e'(wr_data[2:0]);
        end
    end

    assign sel       = sel_q;
    assign cnt       = cnt_q;
    assign match_val = match_q;
    assign ovf       = ovf_q;
    assign hit       = hit_q;

    // R2: with no source selected the counter holds unless written
    a_r2_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == SEL_OFF && !wr_cnt) |=> cnt_q == $past(cnt_q));
    // R8: an overflow pulse follows a wrap to zero
    a_r8_ovf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> cnt_q == '0);
    // R9: a match pulse means the counter equals the match value it was compared with
    a_r9_hit_equal: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> cnt_q == $past(match_q));
    // R10: a counter write loads its value and raises no pulse
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_q == $past(wr_data)) && !ovf_q && !hit_q);

endmodule

// File: rtl/tmr_pair_clksel.sv
// Top level: a shared prescaler, external-clock edge detection, and two
// timer channels with asymmetric cascading. Channel A (index 0) steps on
// B's overflow; channel B (index 1) steps on A's match. Both in cascade
// mode is blocked so neither counts. Reads are combinational.
module tmr_pair_clksel
    import tmr_pair_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int LOG_LO  = 3,
    parameter int LOG_MID = 6,
    parameter int LOG_HI  = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             ovf_a,
    output logic             ovf_b,
    output logic             match_a,
    output logic             match_b
);
    localparam int NCH = 2;

    logic [2:0]       tick;
    logic             ext_rise, ext_fall;
    clk_sel_e         sel   [NCH];
    logic [CNT_W-1:0] cnt   [NCH];
    logic [CNT_W-1:0] mval  [NCH];
    logic [NCH-1:0]   ovf, hit, casc;
    logic             both_cascade;

    tmr_prescaler #(.LOG_LO(LOG_LO), .LOG_MID(LOG_MID), .LOG_HI(LOG_HI)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    tmr_ext_edge u_ext (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .rise(ext_rise), .fall(ext_fall)
    );

    assign both_cascade = (sel[0] == SEL_CASCADE) && (sel[1] == SEL_CASCADE);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [2:0] IDX = 3'(g);
        // Lower channel takes the upper overflow; upper takes the lower match.
        assign casc[g] = (g == 0) ? ovf[1] : hit[0];

        tmr_channel #(.W(CNT_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .ext_rise   (ext_rise),
            .ext_fall   (ext_fall),
            .casc_in    (casc[g]),
            .casc_block (both_cascade),
            .wr_sel     (wr_en && wr_addr == ADDR_SEL_BASE + IDX),
            .wr_cnt     (wr_en && wr_addr == ADDR_CNT_BASE + IDX),
            .wr_match   (wr_en && wr_addr == ADDR_MATCH_BASE + IDX),
            .wr_data    (wr_data),
            .sel        (sel[g]),
            .cnt        (cnt[g]),
            .match_val  (mval[g]),
            .ovf        (ovf[g]),
            .hit        (hit[g])
        );
    end

    // Combinational read-back multiplexer.
    always_comb begin
        unique case (rd_addr)
            3'd0:    rd_data = CNT_W'(sel[0]);
            3'd1:    rd_data = CNT_W'(sel[1]);
            3'd2:    rd_data = cnt[0];
            3'd3:    rd_data = cnt[1];
            3'd4:    rd_data = mval[0];
            3'd5:    rd_data = mval[1];
            default: rd_data = '0;
        endcase
    end

    assign ovf_a   = ovf[0];
    assign ovf_b   = ovf[1];
    assign match_a = hit[0];
    assign match_b = hit[1];

    // R7: with both channels cascaded and no write, neither counter moves
    a_r7_cross_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (both_cascade && !wr_en) |=> (cnt[0] == $past(cnt[0])) && (cnt[1] == $past(cnt[1])));
    // R5: an upper overflow steps a cascaded lower channel on the next edge
    a_r5_chain_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf[1] && sel[0] == SEL_CASCADE && sel[1] != SEL_CASCADE && !wr_en)
            |=> cnt[0] == $past(cnt[0]) + 1'b1);
    // R6: a lower match steps a cascaded upper channel on the next edge
    a_r6_match_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && sel[1] == SEL_CASCADE && sel[0] != SEL_CASCADE && !wr_en)
            |=> cnt[1] == $past(cnt[1]) + 1'b1);

endmodule

// File: tb/tmr_pair_clksel_test.sv
`timescale 1ns/1ps
module tmr_pair_clksel_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ovf_a, ovf_b, match_a, match_b;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int n_ovf_a = 0, n_ovf_b = 0, n_hit_a = 0, n_hit_b = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_pair_clksel uut (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ovf_a(ovf_a), .ovf_b(ovf_b), .match_a(match_a), .match_b(match_b)
    );

    // Edges since reset release.
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // Pulse-high cycle counters, sampled away from the active edge.
    always @(negedge clk) if (rst_n) begin
        if (ovf_a)   n_ovf_a++;
        if (ovf_b)   n_ovf_b++;
        if (match_a) n_hit_a++;
        if (match_b) n_hit_b++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #0.1;
        d = rd_data;
    endtask

    task automatic clr_pulses();
        n_ovf_a = 0; n_ovf_b = 0; n_hit_a = 0; n_hit_b = 0;
    endtask

    // n full periods on the external pin, then settle through the synchronizer.
    task automatic ext_periods(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_clk = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1 reg %0d after reset", a), v, 0);
        end
        chk("R1 pulses low after reset", ovf_a + ovf_b + match_a + match_b, 0);
    endtask

    task automatic t_off();
        logic [7:0] a, b;
        wr(3'd2, 8'h40);
        wr(3'd3, 8'h41);
        ext_periods(3);
        repeat (100) @(negedge clk);
        rd(3'd2, a); rd(3'd3, b);
        chk("R2 A holds with code 0", a, 8'h40);
        chk("R2 B holds with code 0", b, 8'h41);
    endtask

    task automatic t_prescale();
        logic [7:0] a0, a1, b0, b1;
        wr(3'd0, 8'd1);
        wr(3'd1, 8'd2);
        rd(3'd2, a0); rd(3'd3, b0);
        repeat (640) @(negedge clk);
        rd(3'd2, a1); rd(3'd3, b1);
        chk("R3 div8 steps in 640 cycles", 8'(a1 - a0), 80);
        chk("R3 div64 steps in 640 cycles", 8'(b1 - b0), 10);
        wr(3'd0, 8'd3);
        wr(3'd1, 8'd0);
        rd(3'd2, a0);
        repeat (16384) @(negedge clk);
        rd(3'd2, a1);
        chk("R3 div8192 steps in 16384 cycles", 8'(a1 - a0), 2);
    endtask

    task automatic t_ext();
        logic [7:0] a0, a1, b0, b1;
        wr(3'd0, 8'd5);
        wr(3'd1, 8'd6);
        rd(3'd2, a0); rd(3'd3, b0);
        ext_periods(5);
        rd(3'd2, a1); rd(3'd3, b1);
        chk("R4 rising edges counted", 8'(a1 - a0), 5);
        chk("R4 falling edges counted", 8'(b1 - b0), 5);
        wr(3'd0, 8'd7);
        rd(3'd2, a0);
        ext_periods(4);
        rd(3'd2, a1);
        chk("R4 both edges counted", 8'(a1 - a0), 8);
    endtask

    task automatic t_cascade16();
        logic [7:0] a, b;
        wr(3'd0, 8'd4);
        wr(3'd1, 8'd5);
        wr(3'd2, 8'h12);
        wr(3'd3, 8'hFD);
        clr_pulses();
        ext_periods(3);
        rd(3'd2, a); rd(3'd3, b);
        chk("R5 low byte wrapped", b, 8'h00);
        chk("R5 high byte stepped on overflow", a, 8'h13);
        chk("R8 B overflow one cycle", n_ovf_b, 1);
        ext_periods(2);
        rd(3'd2, a); rd(3'd3, b);
        chk("R5 low byte keeps counting", b, 8'h02);
        chk("R5 high byte holds without overflow", a, 8'h13);
    endtask

    task automatic t_ovf_a();
        logic [7:0] a;
        wr(3'd1, 8'd0);
        wr(3'd0, 8'd5);
        wr(3'd2, 8'hFF);
        clr_pulses();
        ext_periods(1);
        rd(3'd2, a);
        chk("R8 A wraps to zero", a, 0);
        chk("R8 A overflow one cycle", n_ovf_a, 1);
    endtask

    task automatic t_match_count();
        logic [7:0] a, b;
        wr(3'd0, 8'd5);
        wr(3'd1, 8'd4);
        wr(3'd4, 8'h05);
        wr(3'd2, 8'h03);
        wr(3'd3, 8'h20);
        clr_pulses();
        ext_periods(2);
        rd(3'd2, a); rd(3'd3, b);
        chk("R9 A reached match value", a, 5);
        chk("R9 match pulse one cycle", n_hit_a, 1);
        chk("R6 B stepped on A match", b, 8'h21);
        ext_periods(2);
        rd(3'd2, a); rd(3'd3, b);
        chk("R9 no further match after passing", n_hit_a, 1);
        chk("R6 B holds without match", b, 8'h21);
    endtask

    task automatic t_cross();
        logic [7:0] a, b;
        wr(3'd0, 8'd4);
        wr(3'd1, 8'd4);
        wr(3'd4, 8'h00);
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'hFF);
        clr_pulses();
        ext_periods(4);
        repeat (50) @(negedge clk);
        rd(3'd2, a); rd(3'd3, b);
        chk("R7 A frozen when both cascade", a, 8'hFF);
        chk("R7 B frozen when both cascade", b, 8'hFF);
        chk("R7 no pulses when both cascade", n_ovf_a + n_ovf_b + n_hit_a + n_hit_b, 0);
    endtask

    task automatic t_write_prio();
        logic [7:0] a;
        wr(3'd1, 8'd0);
        wr(3'd0, 8'd1);
        // A div8 step lands on edges where cyc becomes 1 mod 8 (cyc >= 9).
        do @(negedge clk); while ((cyc % 8) != 0);
        wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h77;
        @(negedge clk);
        wr_en = 1'b0;
        rd(3'd2, a);
        chk("R10 write beats same-cycle step", a, 8'h77);
        repeat (9) @(negedge clk);
        rd(3'd2, a);
        chk("R10 counting resumes after write", a, 8'h78);
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        wr(3'd0, 8'd0);
        wr(3'd5, 8'hA5);
        rd(3'd5, v);
        chk("R11 B match readback", v, 8'hA5);
        wr(3'd1, 8'hF8);
        rd(3'd1, v);
        chk("R11 select upper bits read zero", v, 0);
        wr(3'd6, 8'h5A);
        rd(3'd6, v);
        chk("R11 address 6 reads zero", v, 0);
        rd(3'd5, v);
        chk("R11 write to 6 leaves match B", v, 8'hA5);
        wr(3'd1, 8'hFE);
        rd(3'd1, v);
        chk("R11 select field bits 2:0", v, 6);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_off();
        t_prescale();
        t_ext();
        t_cascade16();
        t_ovf_a();
        t_match_count();
        t_cross();
        t_write_prio();
        t_regmap();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule